// File: doc/BRIEF.md
# Synthesizer Control Word Loader

This block captures the control word of a clock synthesizer and holds it for the analog side. The word holds a 9-bit feedback divide value, a 3-bit output divide code, a 4-bit spread-spectrum code and a 2-bit test-select code. Software or board straps set it in one of two ways. The first is a set of parallel pins that are transparent while a load strobe is low. The second is a three-wire serial port with a shift clock, a data line and a load strobe.

All pins are asynchronous to the block's system clock. Each pin passes through a two-flop synchronizer, and the edges are found in the system clock domain. For that reason the system clock must run at least four times faster than the serial shift clock. A test-observation pin shows one of four sources, chosen by the test-select code. The pin is held low whenever the parallel interface is in control.

Top module: `synth_cfg_loader`

## Requirements
- R1: While `rst` is high, the spread code and the test-select code clear to zero, and the divide outputs take the values on `par_m_i` and `par_n_i`.
- R2: While `par_load_n` is low, `m_o` and `n_o` follow the synchronized parallel pins, and `ssc_o` is forced to 0000. Changes show up three system clocks after the pins change.
- R3: After `par_load_n` rises, `m_o` and `n_o` keep the last parallel values whatever the parallel pins do afterwards.
- R4: While `par_load_n` is high, each rising edge of `ser_clk` shifts `ser_data` into a 21-bit register, first bit first. A full frame carries, from first bit to last: the spread code bits 3 to 0, test-select bits 1 and 0, three ignored bits, the output divide bits 2 to 0, and the feedback divide bits 8 to 0. While `par_load_n` is low, `ser_clk` edges leave the shift register unchanged.
- R5: With `par_load_n` high, a rising edge of `ser_load` copies the shift register into all four outputs. Shifting while `ser_load` is low leaves the outputs unchanged.
- R6: While `ser_load` is high, each rising edge of `ser_clk` puts the freshly shifted register contents on the outputs.
- R7: After `ser_load` falls, the outputs keep their values while further bits are shifted.
- R8: With `par_load_n` high, `test_o` depends on the test-select code `t_o`. Code 00 drives it low. Code 01 drives the oldest bit of the shift register (bit 20). Code 10 drives `mdiv_obs`, and code 11 drives `fouta_obs`.
- R9: `test_o` is low whenever `par_load_n` is low, whatever the test-select code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_load_n | input | 1 | Parallel strobe, low = transparent |
| par_m_i | input | 9 | Parallel feedback divide value |
| par_n_i | input | 3 | Parallel output divide code |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data |
| ser_load | input | 1 | Serial load strobe |
| mdiv_obs | input | 1 | Feedback divider observation signal |
| fouta_obs | input | 1 | Output-A rate observation signal |
| m_o | output | 9 | Held feedback divide value |
| n_o | output | 3 | Held output divide code |
| ssc_o | output | 4 | Held spread-spectrum code |
| t_o | output | 2 | Held test-select code |
| test_o | output | 1 | Test-observation output |

## Verification
The bench targets the frame field order. A design that packed the fields in any other order would load the wrong values into the divide registers and show the wrong bit on `test_o` under code 01. It checks that a load-strobe rise in the middle of a frame transfers the partial contents, and that the outputs freeze once the strobe falls; a design that only loaded on the falling edge, or kept following the shift clock, would disagree at those points. Serial clocks given while the parallel strobe is low must not disturb the frame later transferred. Returning to parallel mode must clear a nonzero spread code and silence `test_o`, even while the test-select code points at a live source.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
    localparam int M_W     = 9;
    localparam int N_W     = 3;
    localparam int SSC_W   = 4;
    localparam int T_W     = 2;
    localparam int PAD_W   = 3;
    localparam int FRAME_W = SSC_W + T_W + PAD_W + N_W + M_W;

    typedef struct packed {
        logic [SSC_W-1:0] ssc;
        logic [T_W-1:0]   tsel;
        logic [N_W-1:0]   ndiv;
        logic [M_W-1:0]   mdiv;
    } cfg_t;

    typedef enum logic [T_W-1:0] {
        TST_LOW   = 2'b00,
        TST_SHIFT = 2'b01,
        TST_MDIV  = 2'b10,
        TST_FOUT  = 2'b11
    } test_sel_e;

    // Frame is shifted MSB-first: spread code occupies the oldest bits.
    function automatic cfg_t frame_to_cfg(input logic [FRAME_W-1:0] f);
        cfg_t c;
        c.mdiv = f[M_W-1:0];
        c.ndiv = f[M_W +: N_W];
        c.tsel = f[M_W + N_W + PAD_W +: T_W];
        c.ssc  = f[FRAME_W-1 -: SSC_W];
        return c;
    endfunction
endpackage

// File: rtl/cfg_sync_bus.sv
module cfg_sync_bus #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/cfg_edge_det.sv
module cfg_edge_det #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg
    import synth_cfg_pkg::*;
#(
    parameter int W = FRAME_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] sr_o,
    output logic [W-1:0] sr_next_o,
    output logic         sout_o
);
    logic [W-1:0] sr_q;

    assign sr_next_o = {sr_q[W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst)           sr_q <= '0;
        else if (shift_en) sr_q <= sr_next_o;
    end

    assign sr_o   = sr_q;
    assign sout_o = sr_q[W-1];

    p_frozen_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> (sr_q == $past(sr_q)));
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold
    import synth_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [M_W-1:0]     rst_m_i,
    input  logic [N_W-1:0]     rst_n_i,
    input  logic               par_mode,
    input  logic [M_W-1:0]     par_m,
    input  logic [N_W-1:0]     par_n,
    input  logic               load_rise,
    input  logic               pass_shift,
    input  logic [FRAME_W-1:0] frame_now,
    input  logic [FRAME_W-1:0] frame_next,
    output cfg_t               cfg_o
);
    cfg_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q.mdiv <= rst_m_i;
            q.ndiv <= rst_n_i;
            q.ssc  <= '0;
            q.tsel <= TST_LOW;
        end else if (par_mode) begin
            q.mdiv <= par_m;
            q.ndiv <= par_n;
            q.ssc  <= '0;
        end else if (pass_shift) begin
            q <= frame_to_cfg(frame_next);
        end else if (load_rise) begin
            q <= frame_to_cfg(frame_now);
        end
    end

    assign cfg_o = q;

    p_par_follow_r2: assert property (@(posedge clk) disable iff (rst)
        par_mode |=> (q.mdiv == $past(par_m) && q.ndiv == $past(par_n) && q.ssc == '0));
    p_transfer_r5: assert property (@(posedge clk) disable iff (rst)
        (!par_mode && load_rise && !pass_shift) |=> (q == frame_to_cfg($past(frame_now))));
    p_pass_through_r6: assert property (@(posedge clk) disable iff (rst)
        (!par_mode && pass_shift) |=> (q == frame_to_cfg($past(frame_next))));
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!par_mode && !load_rise && !pass_shift) |=> (q == $past(q)));
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
    import synth_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             par_load_n,
    input  logic [M_W-1:0]   par_m_i,
    input  logic [N_W-1:0]   par_n_i,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_load,
    input  logic             mdiv_obs,
    input  logic             fouta_obs,
    output logic [M_W-1:0]   m_o,
    output logic [N_W-1:0]   n_o,
    output logic [SSC_W-1:0] ssc_o,
    output logic [T_W-1:0]   t_o,
    output logic             test_o
);
    localparam int CTL_W = 4;
    localparam int PIN_W = M_W + N_W;

    logic [CTL_W-1:0] ctl_s;
    logic [PIN_W-1:0] pins_s;
    logic [1:0]       rise;
    logic             par_n_s, sload_s, sclk_s, sdata_s;
    logic             clk_rise, load_rise_c;
    logic [FRAME_W-1:0] sr, sr_next;
    logic             sout;
    cfg_t             cfg;

    cfg_sync_bus #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) u_ctl_sync (
        .clk(clk), .rst(rst),
        .async_i({par_load_n, ser_load, ser_clk, ser_data}),
        .sync_o(ctl_s)
    );

    cfg_sync_bus #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst(rst),
        .async_i({par_m_i, par_n_i}),
        .sync_o(pins_s)
    );

    assign {par_n_s, sload_s, sclk_s, sdata_s} = ctl_s;

    cfg_edge_det #(.WIDTH(2)) u_edges (
        .clk(clk), .rst(rst),
        .level_i({sload_s, sclk_s}),
        .rise_o(rise)
    );

    assign load_rise_c = rise[1];
    assign clk_rise    = rise[0];

    cfg_shift_reg #(.W(FRAME_W)) u_shift (
        .clk(clk), .rst(rst),
        .shift_en(par_n_s & clk_rise),
        .din(sdata_s),
        .sr_o(sr),
        .sr_next_o(sr_next),
        .sout_o(sout)
    );

    cfg_hold u_hold (
        .clk(clk), .rst(rst),
        .rst_m_i(par_m_i), .rst_n_i(par_n_i),
        .par_mode(~par_n_s),
        .par_m(pins_s[PIN_W-1 -: M_W]),
        .par_n(pins_s[N_W-1:0]),
        .load_rise(load_rise_c),
        .pass_shift(sload_s & clk_rise),
        .frame_now(sr),
        .frame_next(sr_next),
        .cfg_o(cfg)
    );

    always_comb begin
        test_o = 1'b0;
        if (par_n_s) begin
            unique case (test_sel_e'(cfg.tsel))
                TST_LOW:   test_o = 1'b0;
                TST_SHIFT: test_o = sout;
                TST_MDIV:  test_o = mdiv_obs;
                TST_FOUT:  test_o = fouta_obs;
            endcase
        end
    end

    assign m_o   = cfg.mdiv;
    assign n_o   = cfg.ndiv;
    assign ssc_o = cfg.ssc;
    assign t_o   = cfg.tsel;

    p_test_par_low_r9: assert property (@(posedge clk) disable iff (rst)
        !par_n_s |-> !test_o);
    p_test_off_code_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg.tsel == 2'b00) |-> !test_o);
endmodule

// File: tb/sim_synth_cfg_loader.sv
module sim_synth_cfg_loader;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic par_load_n = 1'b0;
    logic [8:0] par_m_i = 9'h019;
    logic [2:0] par_n_i = 3'd3;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic mdiv_obs = 1'b1, fouta_obs = 1'b0;
    logic [8:0] m_o;
    logic [2:0] n_o;
    logic [3:0] ssc_o;
    logic [1:0] t_o;
    logic test_o;

    always #2.5 clk = ~clk;

    synth_cfg_loader u0 (
        .clk(clk), .rst(rst), .par_load_n(par_load_n),
        .par_m_i(par_m_i), .par_n_i(par_n_i),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
        .mdiv_obs(mdiv_obs), .fouta_obs(fouta_obs),
        .m_o(m_o), .n_o(n_o), .ssc_o(ssc_o), .t_o(t_o), .test_o(test_o)
    );

    typedef struct packed {
        logic [8:0] m;
        logic [2:0] n;
        logic [3:0] s;
        logic [1:0] t;
        logic       tst;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0, n_fail = 0;
    bit    done = 0;

    // Reference model state
    logic [20:0] msr = '0;
    logic [8:0]  em;
    logic [2:0]  en;
    logic [3:0]  es;
    logic [1:0]  et;

    function automatic logic [20:0] mk_frame(input logic [3:0] s, input logic [1:0] t,
                                             input logic [2:0] pad, input logic [2:0] n,
                                             input logic [8:0] m);
        return {s, t, pad, n, m};
    endfunction

    task automatic take_frame(input logic [20:0] f);
        es = f[20:17]; et = f[16:15]; en = f[11:9]; em = f[8:0];
    endtask

    function automatic logic exp_test();
        if (!par_load_n) return 1'b0;
        case (et)
            2'b00:   return 1'b0;
            2'b01:   return msr[20];
            2'b10:   return mdiv_obs;
            default: return fouta_obs;
        endcase
    endfunction

    task automatic expect_now(input string tag);
        exp_t e;
        e.m = em; e.n = en; e.s = es; e.t = et; e.tst = exp_test();
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ser_bit(input logic b, input string tag, input bit chk);
        @(negedge clk) ser_data = b;
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        if (par_load_n) begin
            msr = {msr[19:0], b};
            if (ser_load) take_frame(msr);
        end
        settle();
        if (chk) expect_now(tag);
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic ser_frame(input logic [20:0] f, input string tag, input bit chk_each);
        for (int i = 20; i >= 0; i--) ser_bit(f[i], tag, chk_each);
    endtask

    task automatic set_sload(input logic v);
        @(negedge clk) ser_load = v;
        if (v && par_load_n) take_frame(msr);
        settle();
    endtask

    // Monitor: compare scoreboard items as they appear
    initial begin
        forever begin
            exp_t  e;
            string tg;
            wait (exp_q.size() != 0);
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            n_chk++;
            if (m_o !== e.m || n_o !== e.n || ssc_o !== e.s || t_o !== e.t || test_o !== e.tst) begin
                n_fail++;
                $display("FAIL %s: got m=%h n=%0d ssc=%b t=%b test=%b, expected m=%h n=%0d ssc=%b t=%b test=%b",
                         tg, m_o, n_o, ssc_o, t_o, test_o, e.m, e.n, e.s, e.t, e.tst);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [20:0] fa, fb, fc;
        em = 9'h019; en = 3'd3; es = 4'h0; et = 2'b00;
        repeat (4) @(negedge clk);
        expect_now("R1 reset state");
        rst = 1'b0;
        settle();
        expect_now("R1 after reset");

        // R2: parallel pins transparent
        @(negedge clk) begin par_m_i = 9'h01C; par_n_i = 3'd4; end
        em = 9'h01C; en = 3'd4;
        settle();
        expect_now("R2 parallel follow");

        // R3: freeze on strobe rise
        @(negedge clk) par_load_n = 1'b1;
        settle();
        @(negedge clk) begin par_m_i = 9'h1FF; par_n_i = 3'd7; end
        settle();
        expect_now("R3 parallel held");

        // R4/R5: shift full frame with load low, outputs unchanged
        fa = mk_frame(4'b1010, 2'b01, 3'b101, 3'd5, 9'h0AB);
        ser_frame(fa, "R5 no change while shifting", 1'b0);
        expect_now("R5 no change while shifting");
        set_sload(1'b1);
        expect_now("R4 R5 frame transfer on load rise");
        set_sload(1'b0);
        expect_now("R7 values held after load fall");

        // R7 + R8 code 01: shift more bits, outputs hold, test follows oldest bit
        ser_bit(1'b0, "R7 hold during shift", 1'b1);
        ser_bit(1'b1, "R7 hold during shift", 1'b1);
        ser_bit(1'b1, "R8 shift-out observation", 1'b1);

        // R6: pass-through while load held high (partial frame transferred first)
        set_sload(1'b1);
        expect_now("R6 partial transfer on load rise");
        fb = mk_frame(4'b0110, 2'b10, 3'b010, 3'd2, 9'h11E);
        ser_frame(fb, "R6 pass-through", 1'b1);
        expect_now("R8 mdiv observation");
        @(negedge clk) mdiv_obs = 1'b0;
        @(negedge clk);
        expect_now("R8 mdiv observation low");
        set_sload(1'b0);

        // R8 code 11: output-A observation
        fc = mk_frame(4'b1101, 2'b11, 3'b000, 3'd1, 9'h01E);
        ser_frame(fc, "R5 shift frame C", 1'b0);
        set_sload(1'b1);
        set_sload(1'b0);
        expect_now("R8 fouta observation low");
        @(negedge clk) fouta_obs = 1'b1;
        @(negedge clk);
        expect_now("R8 fouta observation high");

        // R9/R2: back to parallel mode
        @(negedge clk) begin par_m_i = 9'h017; par_n_i = 3'd6; par_load_n = 1'b0; end
        em = 9'h017; en = 3'd6; es = 4'h0;
        settle();
        expect_now("R9 test low in parallel, R2 ssc cleared");

        // R4: serial clocks ignored in parallel mode
        ser_bit(1'b0, "R4 ignored shift", 1'b1);
        ser_bit(1'b1, "R4 ignored shift", 1'b1);
        @(negedge clk) par_load_n = 1'b1;
        settle();
        set_sload(1'b1);
        expect_now("R4 frame intact after parallel-mode clocks");
        set_sload(1'b0);

        repeat (5) @(negedge clk);
        wait (exp_q.size() == 0);
        #1;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule